// File: doc/BRIEF.md
# CAN Receive Queue with Mailbox Window

This block holds received CAN frames in a small first-in first-out queue between the protocol engine and the CPU. The protocol engine offers each finished frame on a one-cycle strobe with its 32-bit identifier word, its length code and eight data bytes. The CPU sees only the oldest stored frame. It reads it through a fixed group of window registers, then releases it by writing a release code to a pointer register.

A control register enables the queue and selects what happens when a frame arrives while all entries are occupied. In keep mode the newcomer is discarded. In replace mode the newest stored frame is overwritten. Either way a sticky overrun flag is raised. A receive status flag, gated by an enable bit, drives a registered interrupt line. Acceptance filtering is pass-all. Bit-level reception is outside the block.

Top module: `can_rx_queue_window`

## Requirements
- R1: After reset the control register (address 4) reads 0x80: empty flag (bit 7) set, enable (bit 0) clear, keep mode (bit 3) clear. The receive status (address 7 bit 4), the overrun flag (address 8 bit 0) and irq_rx all read 0.
- R2: Frames come out in arrival order. Address 0 returns the identifier word exactly as received. In that word the extended flag is bit 31, the remote flag is bit 30 and a standard identifier occupies bits 28:18. Address 1 returns the length code in bits 3:0. Addresses 2 and 3 return data bytes 0-3 and 4-7, with byte n in bits 8*(n mod 4)+7 : 8*(n mod 4).
- R3: Up to DEPTH (4) frames are held. The empty flag is 0 whenever at least one frame is stored.
- R4: Only a write of 0xFF to address 5 releases the oldest frame. A write of any other value to that address leaves the window unchanged.
- R5: A release write while the queue is empty has no effect. The empty flag stays set, and later frames are still read in order.
- R6: With keep mode set, a frame that arrives into a full queue is discarded. The stored frames are unchanged and the overrun flag is set.
- R7: With keep mode clear, a frame that arrives into a full queue replaces the newest stored frame. The overrun flag is set.
- R8: While the enable bit is 0, incoming frames are ignored and the queue reads empty. Clearing the enable bit discards all stored frames.
- R9: Storing a frame sets the receive status bit (address 7 bit 4). Writing that bit as 0 clears it. irq_rx is high one cycle after the status bit and the interrupt enable bit (address 6 bit 4) are both set.
- R10: The overrun flag stays set until the CPU writes bit 0 of address 8 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | One-cycle strobe: a received frame is offered |
| frm_id | input | 32 | Identifier word of the offered frame |
| frm_dlc | input | 4 | Length code of the offered frame |
| frm_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| irq_rx | output | 1 | Registered receive interrupt |

## Verification
The assertions assume that frm_valid is a single-cycle strobe sampled on the rising edge. They also assume that register strobes are never asserted together with reset. The bench keeps to this by changing every input on the falling edge and by dropping each strobe after one cycle. It never drives reads and writes in the same cycle. Overflow, release on an empty queue and the flush on disable are each reached on purpose, by counting arrivals against the known depth.

// File: rtl/can_rxq_pkg.sv
package can_rxq_pkg;

  typedef struct packed {
    logic [31:0] id;
    logic [3:0]  dlc;
    logic [63:0] data;
  } rxq_frame_t;

  localparam int unsigned REG_AW = 4;

  localparam logic [REG_AW-1:0] A_WIN_ID   = 4'd0;
  localparam logic [REG_AW-1:0] A_WIN_DLC  = 4'd1;
  localparam logic [REG_AW-1:0] A_WIN_LO   = 4'd2;
  localparam logic [REG_AW-1:0] A_WIN_HI   = 4'd3;
  localparam logic [REG_AW-1:0] A_CTRL     = 4'd4;
  localparam logic [REG_AW-1:0] A_PTR      = 4'd5;
  localparam logic [REG_AW-1:0] A_IEN      = 4'd6;
  localparam logic [REG_AW-1:0] A_ISTAT    = 4'd7;
  localparam logic [REG_AW-1:0] A_OVR      = 4'd8;

  localparam int unsigned CTRL_EN_BIT    = 0;
  localparam int unsigned CTRL_KEEP_BIT  = 3;
  localparam int unsigned CTRL_EMPTY_BIT = 7;
  localparam int unsigned RX_IRQ_BIT     = 4;
  localparam int unsigned OVR_BIT        = 0;

  localparam logic [7:0] RELEASE_CODE = 8'hFF;

endpackage

// File: rtl/can_rxq_store.sv
module can_rxq_store
  import can_rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          enable,
  input  logic                          keep_mode,
  input  logic                          push_req,
  input  rxq_frame_t                    frame_in,
  input  logic                          pop_req,
  output rxq_frame_t                    head,
  output logic [$clog2(DEPTH+1)-1:0]    level,
  output logic [$clog2(DEPTH)-1:0]      rd_ptr,
  output logic [$clog2(DEPTH)-1:0]      wr_ptr,
  output logic                          store_evt,
  output logic                          overrun_evt
);

  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned LVL_W = $clog2(DEPTH+1);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH-1);

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_prev(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_LAST : p - 1'b1;
  endfunction

  rxq_frame_t mem [DEPTH];

  logic             pop_ok;
  logic             full_now;
  logic             push_ok;
  logic             replace_ok;
  logic             mem_we;
  logic [PTR_W-1:0] mem_waddr;

  always_comb begin
    pop_ok      = enable && pop_req && (level != '0);
    full_now    = (level == LVL_FULL) && !pop_ok;
    push_ok     = enable && push_req && !full_now;
    replace_ok  = enable && push_req && full_now && !keep_mode;
    overrun_evt = enable && push_req && full_now;
    store_evt   = push_ok || replace_ok;
    mem_we      = store_evt;
    mem_waddr   = replace_ok ? ptr_prev(wr_ptr) : wr_ptr;
  end

  always_ff @(posedge clk) begin
    if (mem_we) begin
      mem[mem_waddr] <= frame_in;
    end
  end

  assign head = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else begin
      if (pop_ok) begin
        rd_ptr <= ptr_next(rd_ptr);
      end
      if (push_ok) begin
        wr_ptr <= ptr_next(wr_ptr);
      end
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/can_rxq_regs.sv
module can_rxq_regs
  import can_rxq_pkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [REG_AW-1:0]          reg_addr,
  input  logic [DATA_W-1:0]          reg_wdata,
  input  rxq_frame_t                 head,
  input  logic [$clog2(DEPTH+1)-1:0] level,
  input  logic                       store_evt,
  input  logic                       overrun_evt,
  output logic                       enable,
  output logic                       keep_mode,
  output logic                       pop_req,
  output logic                       rx_flag,
  output logic                       ovr_flag,
  output logic [DATA_W-1:0]          reg_rdata,
  output logic                       irq_rx
);

  logic ien_rx;
  logic wr_ctrl, wr_ien, wr_istat, wr_ovr;
  logic q_empty;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
    wr_ien   = reg_wr && (reg_addr == A_IEN);
    wr_istat = reg_wr && (reg_addr == A_ISTAT);
    wr_ovr   = reg_wr && (reg_addr == A_OVR);
    pop_req  = reg_wr && (reg_addr == A_PTR) && (reg_wdata[7:0] == RELEASE_CODE);
    q_empty  = (level == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable    <= 1'b0;
      keep_mode <= 1'b0;
      ien_rx    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        enable    <= reg_wdata[CTRL_EN_BIT];
        keep_mode <= reg_wdata[CTRL_KEEP_BIT];
      end
      if (wr_ien) begin
        ien_rx <= reg_wdata[RX_IRQ_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_flag <= 1'b0;
    end else if (store_evt) begin
      rx_flag <= 1'b1;
    end else if (wr_istat && !reg_wdata[RX_IRQ_BIT]) begin
      rx_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_flag <= 1'b0;
    end else if (overrun_evt) begin
      ovr_flag <= 1'b1;
    end else if (wr_ovr && !reg_wdata[OVR_BIT]) begin
      ovr_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_rx <= 1'b0;
    end else begin
      irq_rx <= rx_flag && ien_rx;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_WIN_ID:  rd_mux = DATA_W'(head.id);
      A_WIN_DLC: rd_mux = DATA_W'(head.dlc);
      A_WIN_LO:  rd_mux = DATA_W'(head.data[31:0]);
      A_WIN_HI:  rd_mux = DATA_W'(head.data[63:32]);
      A_CTRL: begin
        rd_mux[CTRL_EMPTY_BIT] = q_empty;
        rd_mux[CTRL_KEEP_BIT]  = keep_mode;
        rd_mux[CTRL_EN_BIT]    = enable;
      end
      A_IEN:   rd_mux[RX_IRQ_BIT] = ien_rx;
      A_ISTAT: rd_mux[RX_IRQ_BIT] = rx_flag;
      A_OVR:   rd_mux[OVR_BIT]    = ovr_flag;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/can_rx_queue_window.sv
module can_rx_queue_window
  import can_rxq_pkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_valid,
  input  logic [31:0]       frm_id,
  input  logic [3:0]        frm_dlc,
  input  logic [63:0]       frm_data,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_rx
);

  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned LVL_W = $clog2(DEPTH+1);

  rxq_frame_t       frame_in;
  rxq_frame_t       head;
  logic [LVL_W-1:0] level;
  logic [PTR_W-1:0] rd_ptr;
  logic [PTR_W-1:0] wr_ptr;
  logic             store_evt;
  logic             overrun_evt;
  logic             enable;
  logic             keep_mode;
  logic             pop_req;
  logic             rx_flag;
  logic             ovr_flag;

  assign frame_in = '{id: frm_id, dlc: frm_dlc, data: frm_data};

  can_rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .keep_mode   (keep_mode),
    .push_req    (frm_valid),
    .frame_in    (frame_in),
    .pop_req     (pop_req),
    .head        (head),
    .level       (level),
    .rd_ptr      (rd_ptr),
    .wr_ptr      (wr_ptr),
    .store_evt   (store_evt),
    .overrun_evt (overrun_evt)
  );

  can_rxq_regs #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .head        (head),
    .level       (level),
    .store_evt   (store_evt),
    .overrun_evt (overrun_evt),
    .enable      (enable),
    .keep_mode   (keep_mode),
    .pop_req     (pop_req),
    .rx_flag     (rx_flag),
    .ovr_flag    (ovr_flag),
    .reg_rdata   (reg_rdata),
    .irq_rx      (irq_rx)
  );

endmodule

// File: rtl/can_rxq_checker.sv
module can_rxq_checker #(
  parameter int unsigned DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       enable,
  input logic                       keep_mode,
  input logic                       push_req,
  input logic                       pop_req,
  input logic [$clog2(DEPTH+1)-1:0] level,
  input logic [$clog2(DEPTH)-1:0]   rd_ptr,
  input logic [$clog2(DEPTH)-1:0]   wr_ptr,
  input logic                       rx_flag,
  input logic                       ovr_flag
);

  localparam logic [$clog2(DEPTH+1)-1:0] LVL_FULL = ($clog2(DEPTH+1))'(DEPTH);

  assert_level_bound_R3: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_FULL);

  assert_disabled_empty_R8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (level == '0));

  assert_keep_frames_R6: assert property (@(posedge clk) disable iff (rst)
    (enable && keep_mode && push_req && level == LVL_FULL && !pop_req)
    |=> (level == LVL_FULL) && $stable(wr_ptr) && $stable(rd_ptr));

  assert_overrun_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (enable && push_req && level == LVL_FULL && !pop_req) |=> ovr_flag);

  assert_empty_release_R5: assert property (@(posedge clk) disable iff (rst)
    (enable && pop_req && level == '0) |=> $stable(rd_ptr) && (level <= 1));

  assert_store_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (enable && push_req && level < LVL_FULL) |=> rx_flag);

endmodule

bind can_rx_queue_window can_rxq_checker #(.DEPTH(DEPTH)) i_rxq_checker (
  .clk       (clk),
  .rst       (rst),
  .enable    (enable),
  .keep_mode (keep_mode),
  .push_req  (frm_valid),
  .pop_req   (pop_req),
  .level     (level),
  .rd_ptr    (rd_ptr),
  .wr_ptr    (wr_ptr),
  .rx_flag   (rx_flag),
  .ovr_flag  (ovr_flag)
);

// File: tb/test_can_rx_queue_window.sv
`timescale 1ns/1ps
module test_can_rx_queue_window;
  import can_rxq_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frm_valid = 1'b0;
  logic [31:0] frm_id = '0;
  logic [3:0]  frm_dlc = '0;
  logic [63:0] frm_data = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_rx;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  rxq_frame_t exp_q[$];

  always #4 clk = ~clk;

  can_rx_queue_window i_can_rx_queue_window (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_id(frm_id),
    .frm_dlc(frm_dlc), .frm_data(frm_data), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_rx(irq_rx)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic rxq_frame_t mk_frame(input int n);
    rxq_frame_t f;
    if (n % 2 == 0) f.id = {3'b000, 11'(n * 37 + 5), 18'd0};
    else            f.id = {1'b1, 1'(n % 3 == 0), 1'b0, 29'(n * 4099 + 1)};
    f.dlc  = 4'((n % 8) + 1);
    f.data = {8'(n), 8'(n + 1), 8'(n * 3), 8'hA5, 8'(n + 7), 8'h3C, 8'(n * 5), 8'(n ^ 8'h5A)};
    return f;
  endfunction

  // driver: offers a frame and records the expected queue effect
  // mode 0: expect store, 1: expect drop, 2: expect newest replaced
  task automatic drive_frame(input int n, input int mode);
    rxq_frame_t f;
    f = mk_frame(n);
    @(negedge clk);
    frm_valid = 1'b1; frm_id = f.id; frm_dlc = f.dlc; frm_data = f.data;
    @(negedge clk);
    frm_valid = 1'b0;
    if (mode == 0) exp_q.push_back(f);
    else if (mode == 2) exp_q[exp_q.size()-1] = f;
  endtask

  // monitor: reads the window and compares it with the scoreboard head
  task automatic check_head(input string req, input bit release_it);
    logic [31:0] v;
    rxq_frame_t e;
    e = exp_q[0];
    reg_read(A_WIN_ID, v);  chk({req, " id"}, v, e.id);
    reg_read(A_WIN_DLC, v); chk({req, " dlc"}, v, {28'd0, e.dlc});
    reg_read(A_WIN_LO, v);  chk({req, " data lo"}, v, e.data[31:0]);
    reg_read(A_WIN_HI, v);  chk({req, " data hi"}, v, e.data[63:32]);
    if (release_it) begin
      reg_write(A_PTR, 32'hFF);
      void'(exp_q.pop_front());
    end
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    reg_read(A_CTRL, v);  chk("R1 ctrl", v, 32'h80);
    reg_read(A_ISTAT, v); chk("R1 istat", v, 32'h0);
    reg_read(A_OVR, v);   chk("R1 ovr", v, 32'h0);
    chk("R1 irq", {31'd0, irq_rx}, 32'h0);

    // R8 disabled queue ignores frames
    drive_frame(1, 1);
    reg_read(A_CTRL, v);  chk("R8 disabled still empty", v, 32'h80);
    reg_read(A_ISTAT, v); chk("R8 no status when disabled", v, 32'h0);

    // enable, keep mode, interrupt enable
    reg_write(A_CTRL, 32'h09);
    reg_write(A_IEN, 32'h10);
    drive_frame(2, 0);
    repeat (2) @(negedge clk);
    chk("R9 irq after store", {31'd0, irq_rx}, 32'h1);
    reg_read(A_ISTAT, v); chk("R9 status set", v, 32'h10);
    reg_read(A_CTRL, v);  chk("R3 not empty", v, 32'h09);
    reg_write(A_ISTAT, 32'h10);
    reg_read(A_ISTAT, v); chk("R9 write 1 keeps", v, 32'h10);
    reg_write(A_ISTAT, 32'h0);
    reg_read(A_ISTAT, v); chk("R9 write 0 clears", v, 32'h0);
    repeat (2) @(negedge clk);
    chk("R9 irq low", {31'd0, irq_rx}, 32'h0);

    // R4 wrong release value
    reg_write(A_PTR, 32'h7F);
    check_head("R4 head kept after non-release write", 1'b0);

    // R3 fill to depth, R6 keep-mode overflow
    drive_frame(3, 0);
    drive_frame(4, 0);
    drive_frame(5, 0);
    reg_read(A_OVR, v); chk("R3 four stored no overrun", v, 32'h0);
    drive_frame(6, 1);
    reg_read(A_OVR, v); chk("R6 overrun flag", v, 32'h1);
    for (int i = 0; i < 4; i++) check_head("R6 R2 order", 1'b1);
    reg_read(A_CTRL, v); chk("R3 empty after drain", v, 32'h89);
    reg_read(A_OVR, v);  chk("R10 flag sticky", v, 32'h1);
    reg_write(A_OVR, 32'h0);
    reg_read(A_OVR, v);  chk("R10 flag cleared", v, 32'h0);

    // R5 release while empty
    reg_write(A_PTR, 32'hFF);
    reg_read(A_CTRL, v); chk("R5 still empty", v, 32'h89);
    drive_frame(7, 0);
    drive_frame(8, 0);
    check_head("R5 first after empty release", 1'b1);
    check_head("R5 second after empty release", 1'b1);

    // R7 replace mode
    reg_write(A_CTRL, 32'h01);
    for (int i = 9; i < 13; i++) drive_frame(i, 0);
    drive_frame(13, 2);
    reg_read(A_OVR, v); chk("R7 overrun flag", v, 32'h1);
    for (int i = 0; i < 4; i++) check_head("R7 newest replaced", 1'b1);
    reg_write(A_OVR, 32'h0);

    // R8 flush on disable
    drive_frame(14, 0);
    drive_frame(15, 0);
    reg_write(A_CTRL, 32'h00);
    reg_read(A_CTRL, v); chk("R8 flush on disable", v, 32'h80);
    reg_write(A_CTRL, 32'h01);
    reg_read(A_CTRL, v); chk("R8 empty after re-enable", v, 32'h81);
    exp_q.delete();
    drive_frame(16, 0);
    check_head("R8 fresh frame after flush", 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule